// File: doc/BRIEF.md
# Ethernet Receive Statistics Counter Bank

This block keeps the receive-side statistics of an Ethernet MAC. Upstream logic that has parsed a frame and checked its CRC presents a one-cycle frame summary on a valid strobe. The summary carries the byte length, CRC result, alignment error, broadcast and multicast flags, a pause-frame flag, a receive-overflow flag, a drop flag and the current maximum frame length. The block registers the summary. In the next cycle it bumps every counter the frame qualifies for: totals, address-type counts, error classes, runt and long-frame classes, and a seven-bin length histogram. It also adds the frame length to two octet accumulators, one for all frames and one for error-free frames only.

Software-side logic reads any counter by index through a registered read port. A synchronous clear input zeroes the whole bank. Counter index map (used by the read port): 0 drop, 1 all frames, 2 broadcast, 3 multicast, 4 CRC-or-alignment error, 5 short with good CRC, 6 long with good CRC, 7 short with bad CRC, 8 long with bad CRC, 9 to 15 histogram bins (exactly 64, 65-127, 128-255, 256-511, 512-1023, 1024-2047, 2048 and up), 16 all octets, 17 error-free frames, 18 CRC errors, 19 alignment errors, 20 receive overflows, 21 pause frames, 22 error-free octets.

Top module: `rx_stat_bank`

## Requirements
- R1: After reset every counter reads zero and `rd_data_o` is zero.
- R2: A frame that is not dropped increments counter 1 and adds its length to counter 16. The broadcast flag increments counter 2 and the multicast flag increments counter 3.
- R3: A frame shorter than 64 bytes increments counter 5 if its CRC is good and counter 7 if its CRC is bad, never both.
- R4: A frame longer than the maximum length sampled with its strobe increments counter 6 if its CRC is good and counter 8 if its CRC is bad. A frame exactly at the maximum increments neither. The sampled maximum resets to 1518.
- R5: Every counted frame of 64 bytes or more increments exactly one histogram bin among counters 9 to 15, chosen by the ranges above. Shorter frames increment none.
- R6: A bad CRC increments counter 18, an alignment error counter 19, either of them counter 4, the overflow flag counter 20 and the pause flag counter 21.
- R7: A frame with a good CRC, no alignment error and no overflow increments counter 17 and adds its length to counter 22. Any other frame leaves both unchanged.
- R8: A frame with the drop flag set increments counter 0 and changes no other counter.
- R9: Counters wrap modulo 2^CNT_W, including the octet accumulators.
- R10: A read with `rd_en_i` high returns the indexed counter on `rd_data_o` after the next rising edge. Indices 23 and above return zero.
- R11: `clr_i` zeroes every counter at the next edge. When it coincides with a frame's commit edge, the clear wins and that frame is lost.
- R12: Strobes are at least two cycles apart. A frame's updates commit at the edge after its strobe is sampled, so a read sampled at that commit edge still returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_valid_i | input | 1 | Frame summary strobe |
| fr_len_i | input | 16 | Frame length in bytes |
| fr_crc_ok_i | input | 1 | CRC check passed |
| fr_align_err_i | input | 1 | Alignment error |
| fr_bcast_i | input | 1 | Broadcast destination |
| fr_mcast_i | input | 1 | Multicast destination |
| fr_pause_i | input | 1 | Flow-control pause frame |
| fr_ovf_i | input | 1 | Receive FIFO overflow during frame |
| fr_drop_i | input | 1 | Frame could not be counted |
| max_len_i | input | 11 | Maximum frame length, sampled with the strobe |
| clr_i | input | 1 | Zero all counters |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 5 | Counter index to read |
| rd_data_o | output | CNT_W | Read data, registered |

## Verification
A frame's counter commit and a clear can land on the same clock edge. The bench provokes this by strobing a frame and raising `clr_i` in the following cycle, then reading the whole bank to confirm that nothing of that frame survived. A read can also fall on a frame's commit edge. The bench issues one there and expects the pre-update count, then reads again one cycle later and expects the incremented value.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int LEN_W   = 16;
  localparam int MAXL_W  = 11;
  localparam int NUM_CNT = 23;
  localparam int IDX_W   = 5;

  localparam int CI_DROP     = 0;
  localparam int CI_ALL      = 1;
  localparam int CI_BCAST    = 2;
  localparam int CI_MCAST    = 3;
  localparam int CI_CRC_ALN  = 4;
  localparam int CI_SHORT_OK = 5;
  localparam int CI_LONG_OK  = 6;
  localparam int CI_SHORT_BD = 7;
  localparam int CI_LONG_BD  = 8;
  localparam int CI_HIST0    = 9;
  localparam int NUM_BINS    = 7;
  localparam int CI_OCT_ALL  = 16;
  localparam int CI_GOOD     = 17;
  localparam int CI_CRC      = 18;
  localparam int CI_ALIGN    = 19;
  localparam int CI_OVF      = 20;
  localparam int CI_PAUSE    = 21;
  localparam int CI_OCT_GOOD = 22;

  localparam int MIN_LEN = 64;

  typedef struct packed {
    logic [LEN_W-1:0]  len;
    logic              crc_ok;
    logic              align_err;
    logic              bcast;
    logic              mcast;
    logic              pause;
    logic              ovf;
    logic              drop;
    logic [MAXL_W-1:0] max_len;
  } rx_sum_t;
endpackage

// File: rtl/rxs_capture.sv
module rxs_capture
  import rxs_pkg::*;
#(
  parameter int MAXLEN_RST = 1518
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    valid_i,
  input  rx_sum_t sum_i,
  output logic    valid_q,
  output rx_sum_t sum_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q       <= 1'b0;
      sum_q         <= '0;
      sum_q.max_len <= MAXL_W'(MAXLEN_RST);
    end else begin
      valid_q <= valid_i;
      if (valid_i) sum_q <= sum_i;
    end
  end
endmodule

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
(
  input  logic               valid_i,
  input  rx_sum_t            sum_i,
  output logic [NUM_CNT-1:0] inc_o,
  output logic [LEN_W-1:0]   add_all_o,
  output logic [LEN_W-1:0]   add_good_o
);
  logic crc_bad, any_err, is_short, is_long;
  logic [LEN_W-1:0] lim;

  always_comb begin
    lim      = LEN_W'(sum_i.max_len);
    crc_bad  = ~sum_i.crc_ok;
    any_err  = crc_bad | sum_i.align_err | sum_i.ovf;
    is_short = sum_i.len < LEN_W'(MIN_LEN);
    is_long  = sum_i.len > lim;

    inc_o      = '0;
    add_all_o  = sum_i.len;
    add_good_o = sum_i.len;

    if (valid_i) begin
      if (sum_i.drop) begin
        inc_o[CI_DROP] = 1'b1;
      end else begin
        inc_o[CI_ALL]      = 1'b1;
        inc_o[CI_OCT_ALL]  = 1'b1;
        inc_o[CI_BCAST]    = sum_i.bcast;
        inc_o[CI_MCAST]    = sum_i.mcast;
        inc_o[CI_CRC_ALN]  = crc_bad | sum_i.align_err;
        inc_o[CI_CRC]      = crc_bad;
        inc_o[CI_ALIGN]    = sum_i.align_err;
        inc_o[CI_OVF]      = sum_i.ovf;
        inc_o[CI_PAUSE]    = sum_i.pause;
        inc_o[CI_GOOD]     = ~any_err;
        inc_o[CI_OCT_GOOD] = ~any_err;
        inc_o[CI_SHORT_OK] = is_short & sum_i.crc_ok;
        inc_o[CI_SHORT_BD] = is_short & crc_bad;
        inc_o[CI_LONG_OK]  = is_long & sum_i.crc_ok;
        inc_o[CI_LONG_BD]  = is_long & crc_bad;
        // histogram: bin0 exactly MIN_LEN, bin1 up to 2*MIN_LEN-1,
        // bins 2..5 power-of-two octaves, last bin open ended
        inc_o[CI_HIST0] = sum_i.len == LEN_W'(MIN_LEN);
        inc_o[CI_HIST0+1] = (sum_i.len > LEN_W'(MIN_LEN)) &&
                            (sum_i.len < LEN_W'(2*MIN_LEN));
        for (int j = 2; j < NUM_BINS-1; j++) begin
          inc_o[CI_HIST0+j] = (sum_i.len >= LEN_W'(MIN_LEN << (j-1))) &&
                              (sum_i.len <  LEN_W'(MIN_LEN << j));
        end
        inc_o[CI_HIST0+NUM_BINS-1] =
          sum_i.len >= LEN_W'(MIN_LEN << (NUM_BINS-2));
      end
    end
  end
endmodule

// File: rtl/rxs_counter_bank.sv
module rxs_counter_bank
  import rxs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr_i,
  input  logic [NUM_CNT-1:0] inc_i,
  input  logic [LEN_W-1:0]   add_all_i,
  input  logic [LEN_W-1:0]   add_good_i,
  input  logic               rd_en_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [CNT_W-1:0]   rd_data_o
);
  logic [CNT_W-1:0] cnt_val [NUM_CNT];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] cnt_q;
    if (i == CI_OCT_ALL) begin : g_oa
      assign step = CNT_W'(add_all_i);
    end else if (i == CI_OCT_GOOD) begin : g_og
      assign step = CNT_W'(add_good_i);
    end else begin : g_one
      assign step = CNT_W'(1);
    end
    always_ff @(posedge clk) begin
      if (rst || clr_i)  cnt_q <= '0;
      else if (inc_i[i]) cnt_q <= cnt_q + step;
    end
    assign cnt_val[i] = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o <= '0;
    end else if (rd_en_i) begin
      if (int'(rd_idx_i) < NUM_CNT) rd_data_o <= cnt_val[rd_idx_i];
      else                          rd_data_o <= '0;
    end
  end
endmodule

// File: rtl/rx_stat_bank.sv
module rx_stat_bank
  import rxs_pkg::*;
#(
  parameter int CNT_W      = 32,
  parameter int MAXLEN_RST = 1518
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fr_valid_i,
  input  logic [15:0]       fr_len_i,
  input  logic              fr_crc_ok_i,
  input  logic              fr_align_err_i,
  input  logic              fr_bcast_i,
  input  logic              fr_mcast_i,
  input  logic              fr_pause_i,
  input  logic              fr_ovf_i,
  input  logic              fr_drop_i,
  input  logic [10:0]       max_len_i,
  input  logic              clr_i,
  input  logic              rd_en_i,
  input  logic [4:0]        rd_idx_i,
  output logic [CNT_W-1:0]  rd_data_o
);
  rx_sum_t            sum_in, cap_sum;
  logic               cap_vld;
  logic [NUM_CNT-1:0] inc_vec;
  logic [LEN_W-1:0]   add_all, add_good;

  always_comb begin
    sum_in.len       = fr_len_i;
    sum_in.crc_ok    = fr_crc_ok_i;
    sum_in.align_err = fr_align_err_i;
    sum_in.bcast     = fr_bcast_i;
    sum_in.mcast     = fr_mcast_i;
    sum_in.pause     = fr_pause_i;
    sum_in.ovf       = fr_ovf_i;
    sum_in.drop      = fr_drop_i;
    sum_in.max_len   = max_len_i;
  end

  rxs_capture #(.MAXLEN_RST(MAXLEN_RST)) u_cap (
    .clk(clk), .rst(rst), .valid_i(fr_valid_i), .sum_i(sum_in),
    .valid_q(cap_vld), .sum_q(cap_sum)
  );

  rxs_classify u_cls (
    .valid_i(cap_vld), .sum_i(cap_sum), .inc_o(inc_vec),
    .add_all_o(add_all), .add_good_o(add_good)
  );

  rxs_counter_bank #(.CNT_W(CNT_W)) u_bank (
    .clk(clk), .rst(rst), .clr_i(clr_i), .inc_i(inc_vec),
    .add_all_i(add_all), .add_good_i(add_good),
    .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o)
  );
endmodule

// File: rtl/rx_stat_bank_chk.sv
module rx_stat_bank_chk
  import rxs_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               fr_valid_i,
  input logic               clr_i,
  input logic               rd_en_i,
  input logic [IDX_W-1:0]   rd_idx_i,
  input logic [CNT_W-1:0]   rd_data_o,
  input logic               cap_vld,
  input logic               cap_drop,
  input logic [NUM_CNT-1:0] inc_vec
);
  // R1: reset leaves the read register at zero
  a_r1_rst_zero: assert property (@(posedge clk) rst |=> rd_data_o == '0);

  // R10: out-of-range index reads zero
  a_r10_rd_oob: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && int'(rd_idx_i) >= NUM_CNT) |=> rd_data_o == '0);

  // R11: a read one cycle after a clear returns zero
  a_r11_clr_read: assert property (@(posedge clk) disable iff (rst)
    clr_i ##1 rd_en_i |=> rd_data_o == '0);

  // R8: a dropped frame touches only the drop counter
  a_r8_drop_only: assert property (@(posedge clk) disable iff (rst)
    (cap_vld && cap_drop) |-> inc_vec == NUM_CNT'(1));

  // R3: short-frame classes never both
  a_r3_short_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({inc_vec[CI_SHORT_OK], inc_vec[CI_SHORT_BD]}));

  // R5: at most one histogram bin per frame
  a_r5_bin_one: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc_vec[CI_HIST0 +: NUM_BINS]));

  // R7: error-free count excludes CRC and alignment errors
  a_r7_good_excl: assert property (@(posedge clk) disable iff (rst)
    inc_vec[CI_GOOD] |-> !inc_vec[CI_CRC] && !inc_vec[CI_ALIGN] && !inc_vec[CI_OVF]);

  // R12: strobes spaced at least two cycles apart, nothing counted without one
  a_r12_spacing: assert property (@(posedge clk) disable iff (rst)
    fr_valid_i |=> !fr_valid_i);
  a_r12_commit: assert property (@(posedge clk) disable iff (rst)
    !$past(fr_valid_i) |-> inc_vec == '0);
endmodule

bind rx_stat_bank rx_stat_bank_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fr_valid_i(fr_valid_i), .clr_i(clr_i),
  .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
  .cap_vld(cap_vld), .cap_drop(cap_sum.drop), .inc_vec(inc_vec)
);

// File: tb/rx_stat_bank_bench.sv
module rx_stat_bank_bench;
  localparam int NCNT = 23;
  localparam int NW   = 12;
  localparam int NV   = 19;
  // entry: {len16, crc_ok, align, bcast, mcast, pause, ovf, drop, max11}
  localparam logic [33:0] VEC [NV] = '{
    {16'd64,   7'b1010000, 11'd1518},
    {16'd63,   7'b1000000, 11'd1518},
    {16'd10,   7'b0000000, 11'd1518},
    {16'd1518, 7'b1000000, 11'd1518},
    {16'd1519, 7'b1000000, 11'd1518},
    {16'd1600, 7'b0000000, 11'd1518},
    {16'd127,  7'b1001000, 11'd1518},
    {16'd128,  7'b1100000, 11'd1518},
    {16'd255,  7'b1000100, 11'd1518},
    {16'd256,  7'b1000010, 11'd1518},
    {16'd511,  7'b1010000, 11'd1518},
    {16'd512,  7'b0001000, 11'd1518},
    {16'd1023, 7'b1000000, 11'd1518},
    {16'd1024, 7'b1000000, 11'd1518},
    {16'd2047, 7'b1000000, 11'd2047},
    {16'd3000, 7'b1000000, 11'd2047},
    {16'd100,  7'b1010001, 11'd1518},
    {16'd200,  7'b0100000, 11'd100},
    {16'd65,   7'b1110011, 11'd1518}
  };

  logic clk = 0, rst = 1;
  logic fr_valid = 0, crc_ok = 0, aln = 0, bc = 0, mc = 0, pse = 0, ovf = 0, drp = 0;
  logic [15:0] len = 0;
  logic [10:0] maxl = 0;
  logic clr = 0, rd_en = 0;
  logic [4:0] rd_idx = 0;
  logic [31:0] rd_data;
  logic [NW-1:0] rd_data_n;
  int checks = 0, fails = 0;
  longint unsigned exp_c [NCNT];
  bit done = 0;

  always #4 clk = ~clk;

  rx_stat_bank u_rx_stat_bank (
    .clk(clk), .rst(rst), .fr_valid_i(fr_valid), .fr_len_i(len),
    .fr_crc_ok_i(crc_ok), .fr_align_err_i(aln), .fr_bcast_i(bc), .fr_mcast_i(mc),
    .fr_pause_i(pse), .fr_ovf_i(ovf), .fr_drop_i(drp), .max_len_i(maxl),
    .clr_i(clr), .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data));

  rx_stat_bank #(.CNT_W(NW)) u_rx_stat_bank_narrow (
    .clk(clk), .rst(rst), .fr_valid_i(fr_valid), .fr_len_i(len),
    .fr_crc_ok_i(crc_ok), .fr_align_err_i(aln), .fr_bcast_i(bc), .fr_mcast_i(mc),
    .fr_pause_i(pse), .fr_ovf_i(ovf), .fr_drop_i(drp), .max_len_i(maxl),
    .clr_i(clr), .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data_n));

  function automatic string tag_of(int i);
    case (i)
      0: return "R8";
      1, 2, 3, 16: return "R2";
      5, 7: return "R3";
      6, 8: return "R4";
      17, 22: return "R7";
      default: return (i >= 9 && i <= 15) ? "R5" : "R6";
    endcase
  endfunction

  task automatic check(string tag, int idx, longint unsigned act, longint unsigned expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, idx, act, expv);
    end
  endtask

  task automatic send(logic [33:0] e);
    @(negedge clk);
    {len, crc_ok, aln, bc, mc, pse, ovf, drp, maxl} = e;
    fr_valid = 1;
    @(negedge clk);
    fr_valid = 0;
    @(negedge clk);
  endtask

  task automatic rd(int idx);
    rd_en = 1; rd_idx = 5'(idx);
    @(negedge clk);
    rd_en = 0;
  endtask

  task automatic model(logic [33:0] e);
    logic [15:0] l; logic [10:0] m;
    logic ok, a, b, mu, p, o, d;
    {l, ok, a, b, mu, p, o, d, m} = e;
    if (d) begin exp_c[0]++; return; end
    exp_c[1]++; exp_c[16] += l;
    if (b) exp_c[2]++;
    if (mu) exp_c[3]++;
    if (!ok || a) exp_c[4]++;
    if (l < 64) begin if (ok) exp_c[5]++; else exp_c[7]++; end
    if (l > 16'(m)) begin if (ok) exp_c[6]++; else exp_c[8]++; end
    if (l == 64) exp_c[9]++;
    else if (l >= 65 && l <= 127) exp_c[10]++;
    else if (l >= 128 && l <= 255) exp_c[11]++;
    else if (l >= 256 && l <= 511) exp_c[12]++;
    else if (l >= 512 && l <= 1023) exp_c[13]++;
    else if (l >= 1024 && l <= 2047) exp_c[14]++;
    else if (l >= 2048) exp_c[15]++;
    if (!ok) exp_c[18]++;
    if (a) exp_c[19]++;
    if (o) exp_c[20]++;
    if (p) exp_c[21]++;
    if (ok && !a && !o) begin exp_c[17]++; exp_c[22] += l; end
  endtask

  task automatic check_all(string ovr);
    for (int i = 0; i < NCNT; i++) begin
      rd(i);
      check(ovr == "" ? tag_of(i) : ovr, i, rd_data, exp_c[i] & 64'hFFFF_FFFF);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCNT; i++) exp_c[i] = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1", -1, rd_data, 0);
    check_all("R1");

    // table walk (R2..R8 via tag_of)
    for (int v = 0; v < NV; v++) begin
      send(VEC[v]);
      model(VEC[v]);
      check_all("");
    end

    // R10: out-of-range indices read zero
    rd(23); check("R10", 23, rd_data, 0);
    rd(31); check("R10", 31, rd_data, 0);
    rd(1);  check("R10", 1, rd_data, exp_c[1]);

    // R12: read sampled on the commit edge returns the old value
    @(negedge clk);
    {len, crc_ok, aln, bc, mc, pse, ovf, drp, maxl} = {16'd300, 7'b1000000, 11'd1518};
    fr_valid = 1;
    @(negedge clk);
    fr_valid = 0; rd_en = 1; rd_idx = 5'd1;
    @(negedge clk);
    rd_en = 0;
    check("R12", 1, rd_data, exp_c[1]);
    model({16'd300, 7'b1000000, 11'd1518});
    rd(1); check("R12", 1, rd_data, exp_c[1]);
    rd(12); check("R12", 12, rd_data, exp_c[12]);

    // R11: clear coincides with a commit edge, clear wins
    @(negedge clk);
    {len, crc_ok, aln, bc, mc, pse, ovf, drp, maxl} = {16'd64, 7'b1010000, 11'd1518};
    fr_valid = 1;
    @(negedge clk);
    fr_valid = 0; clr = 1;
    @(negedge clk);
    clr = 0;
    for (int i = 0; i < NCNT; i++) exp_c[i] = 0;
    check_all("R11");

    // R9: narrow instance octet counter wraps
    for (int k = 0; k < 3; k++) begin
      send({16'd2000, 7'b1000000, 11'd2047});
      model({16'd2000, 7'b1000000, 11'd2047});
    end
    rd(16); check("R9", 16, rd_data_n, 6000 % 4096);
    check("R9", 16, rd_data, 6000);
    rd(22); check("R9", 22, rd_data_n, 6000 % 4096);
    rd(1);  check("R9", 1, rd_data_n, 3);

    // R11: clear alone
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    rd(16); check("R11", 16, rd_data, 0);
    rd(1);  check("R11", 1, rd_data, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule